// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block watches over software with a 10-bit down-counter. The counter is clocked through a two-stage divider. The first stage passes every clock or one clock in 256. The second stage divides that rate by a power of two from 1 to 128. Software restarts the counter by writing a key word to a kick register. The kick is honoured only when the count has already fallen to or below a programmed window threshold.

A kick that comes while the count is still above the threshold is treated as a fault. So is a counter that runs out. Either fault is raised as a reset request or as an interrupt, as chosen in the control register. A separate warning flag rises when the count reaches a programmed level, so software gets notice before the counter runs out. All flags are sticky and are cleared by writing 1 to them. A freeze input, driven for example while a debugger halts the processor, stops the count.

Internally a three-state controller sequences the block:
- **Idle**: the counter is stopped.
- **Run**: the counter is counting.
- **Trip**: a fault has been seen and the counter is held.

The transitions are named as follows:
- **Start** (Idle→Run): enable set; the reload value is loaded.
- **Early** (Run→Trip): a keyed kick arrives above the window.
- **Expire** (Run→Trip): a divider tick arrives at count 0.
- **Stop** (Run→Idle or Trip→Idle): enable cleared.
- **Recover** (Trip→Run): both fault flags are cleared while enable is still set; the reload value is loaded.
- **Kick** (Run→Run): a keyed kick inside the window reloads the counter.

Top module: `wwdt_top`

Register map, on a 3-bit address:

| Address | Register | Contents |
|---------|----------|----------|
| 0 | control | bit 0 enable; bit 1 fault action (0 = reset request, 1 = interrupt); bit 2 first-stage select (0 = ÷1, 1 = ÷256); bits 5:3 second-stage exponent n (÷2^n) |
| 1 | window | window threshold |
| 2 | warning | warning level |
| 3 | reload | reload value |
| 4 | kick | write-only; reads 0 |
| 5 | status | bit 0 warning; bit 1 underflow fault; bit 2 early-kick fault |
| 6 | count | current count |

## Requirements
- R1: After reset the outputs are low and the registers read as follows:
  - control 0;
  - window 0x3FF;
  - warning level 0;
  - reload value 0x3FF;
  - kick 0;
  - status 0;
  - count 0x3FF.
- R2: In Run the counter steps once every (256 if control bit 2 else 1) × 2^(control bits 5:3) clocks. The period restarts from zero at every load.
- R3: Setting control bit 0 takes Idle to Run on the next clock and loads the reload value (Start). Clearing it takes the block to Idle, where the count holds (Stop).
- R4: Each divider tick in Run lowers a non-zero count by exactly one.
- R5: A tick at count 0 sets status bit 1 and enters Trip (Expire).
- R6: A keyed kick while the count is above the window sets status bit 2 and enters Trip without reloading the count (Early).
- R7: A keyed kick while the count is at or below the window loads the reload value and restarts the divider (Kick).
- R8: A write to the kick address has no effect in these cases:
  - the data differs from the key 0xA5C3;
  - the block is in Idle.
- R9: The tick that brings the count to the warning level sets status bit 0, which drives warn_irq. Writing 1 to status bit 0 clears it.
- R10: While status bit 1 or bit 2 is set, the fault drives one of two outputs:
  - control bit 1 = 0: fault_rst_req is high;
  - control bit 1 = 1: fault_irq is high.
- R11: Writing 1 to a status bit clears it. Once both fault bits are clear in Trip with enable set, the next clock enters Run with the reload value loaded (Recover).
- R12: While freeze is high, neither the count nor the divider advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | Pauses counting while high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| fault_rst_req | output | 1 | Fault raised as a reset request |
| fault_irq | output | 1 | Fault raised as an interrupt |
| warn_irq | output | 1 | Warning flag |

## Verification
Register writes take effect at the clock edge that samples them. A kick, a status clear or a fault is therefore visible on the count, the status bits and the fault outputs half a clock later. A Start or a Recover needs one more edge, because the new enable or the cleared flags must first be registered. With a divider period P, the first step after a load lands exactly P edges after the load edge. The bench advances a behavioural model at every rising edge and compares all outputs and the addressed read data at every falling edge. Its directed checks read the count on consecutive falling edges, so each value is seen at the edge where it is due.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TRIP = 2'd2
    } wd_state_e;

    // control register layout, bit 0 at the bottom
    typedef struct packed {
        logic [2:0] post_sel;
        logic       pre_sel;
        logic       act_irq;
        logic       en;
    } wd_ctrl_t;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_WIN    = 3'd1;
    localparam logic [ADDR_W-1:0] A_WARN   = 3'd2;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd3;
    localparam logic [ADDR_W-1:0] A_KICK   = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd6;

endpackage

// File: rtl/wwdt_clkdiv.sv
module wwdt_clkdiv #(
    parameter int PRE_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic             pre_sel,
    input  logic [SEL_W-1:0] post_sel,
    output logic             tick
);
    localparam int POST_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0]  pre_q;
    logic [POST_W-1:0] post_q;
    logic [POST_W-1:0] post_lim;
    logic              pre_done;
    logic              post_done;

    always_comb begin
        post_lim  = POST_W'((32'd1 << post_sel) - 32'd1);
        pre_done  = !pre_sel || (pre_q == '1);
        post_done = (post_q == post_lim);
        tick      = adv && pre_done && post_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            post_q <= '0;
        end else if (clr) begin
            pre_q  <= '0;
            post_q <= '0;
        end else if (adv) begin
            if (pre_done) begin
                pre_q  <= '0;
                post_q <= post_done ? '0 : post_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // R2: a tick restarts both stages
    a_r2_tick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_q == '0 && post_q == '0));

    // R12: no advance means both stages hold
    a_r12_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> ($stable(pre_q) && $stable(post_q)));

endmodule

// File: rtl/wwdt_regs.sv
module wwdt_regs
    import wwdt_pkg::*;
#(
    parameter int              DATA_W   = 16,
    parameter int              CNT_W    = 10,
    parameter logic [DATA_W-1:0] KICK_KEY = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ev_warn,
    input  logic              ev_under,
    input  logic              ev_early,
    input  logic [CNT_W-1:0]  cnt_val,
    output wd_ctrl_t          ctrl,
    output logic [CNT_W-1:0]  win,
    output logic [CNT_W-1:0]  warn_lvl,
    output logic [CNT_W-1:0]  reload_val,
    output logic              kick,
    output logic              flag_warn,
    output logic              flag_under,
    output logic              flag_early,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int CTRL_W = $bits(wd_ctrl_t);

    logic       stat_wr;
    logic [2:0] clr_mask;

    always_comb begin
        kick     = bus_wr && (bus_addr == A_KICK) && (bus_wdata == KICK_KEY);
        stat_wr  = bus_wr && (bus_addr == A_STAT);
        clr_mask = stat_wr ? bus_wdata[2:0] : 3'b000;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl       <= '0;
            win        <= '1;
            warn_lvl   <= '0;
            reload_val <= '1;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL:   ctrl       <= wd_ctrl_t'(bus_wdata[CTRL_W-1:0]);
                A_WIN:    win        <= bus_wdata[CNT_W-1:0];
                A_WARN:   warn_lvl   <= bus_wdata[CNT_W-1:0];
                A_RELOAD: reload_val <= bus_wdata[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    // sticky flags: a new event wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_warn  <= 1'b0;
            flag_under <= 1'b0;
            flag_early <= 1'b0;
        end else begin
            flag_warn  <= ev_warn  || (flag_warn  && !clr_mask[0]);
            flag_under <= ev_under || (flag_under && !clr_mask[1]);
            flag_early <= ev_early || (flag_early && !clr_mask[2]);
        end
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:   bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
            A_WIN:    bus_rdata = {{(DATA_W-CNT_W){1'b0}}, win};
            A_WARN:   bus_rdata = {{(DATA_W-CNT_W){1'b0}}, warn_lvl};
            A_RELOAD: bus_rdata = {{(DATA_W-CNT_W){1'b0}}, reload_val};
            A_STAT:   bus_rdata = {{(DATA_W-3){1'b0}}, flag_early, flag_under, flag_warn};
            A_COUNT:  bus_rdata = {{(DATA_W-CNT_W){1'b0}}, cnt_val};
            default:  bus_rdata = '0;
        endcase
    end

    // R11: writing 1 clears an underflow flag unless a new underflow arrives
    a_r11_w1c_under: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && bus_wdata[1] && !ev_under) |=> !flag_under);

    // R9: the warning flag stays until software clears it
    a_r9_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_warn && !(stat_wr && bus_wdata[0])) |=> flag_warn);

endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
    import wwdt_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             freeze,
    input  logic             kick,
    input  logic             tick,
    input  logic             fault_any,
    input  logic [CNT_W-1:0] win,
    input  logic [CNT_W-1:0] warn_lvl,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             adv,
    output logic             clr,
    output logic             ev_warn,
    output logic             ev_under,
    output logic             ev_early
);
    wd_state_e state_q, state_d;
    logic      ld, dec;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions and the actions they carry
    always_comb begin
        state_d  = state_q;
        ld       = 1'b0;
        dec      = 1'b0;
        ev_warn  = 1'b0;
        ev_under = 1'b0;
        ev_early = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en) begin
                    state_d = ST_RUN;
                    ld      = 1'b1;
                end
            end
            ST_RUN: begin
                if (!en) begin
                    state_d = ST_IDLE;
                end else if (kick) begin
                    if (cnt_q <= win) begin
                        ld = 1'b1;
                    end else begin
                        ev_early = 1'b1;
                        state_d  = ST_TRIP;
                    end
                end else if (tick) begin
                    if (cnt_q == '0) begin
                        ev_under = 1'b1;
                        state_d  = ST_TRIP;
                    end else begin
                        dec     = 1'b1;
                        ev_warn = ((cnt_q - 1'b1) == warn_lvl);
                    end
                end
            end
            ST_TRIP: begin
                if (!en) begin
                    state_d = ST_IDLE;
                end else if (!fault_any) begin
                    state_d = ST_RUN;
                    ld      = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs to the divider
    always_comb begin
        adv = (state_q == ST_RUN) && !freeze;
        clr = ld || (state_q != ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '1;
        else if (ld)  cnt_q <= reload_val;
        else if (dec) cnt_q <= cnt_q - 1'b1;
    end

    // R4: a tick at a non-zero count lowers it by one
    a_r4_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && en && !kick && tick && cnt_q != '0)
        |=> cnt_q == $past(cnt_q) - 1'b1);

    // R5: a tick at zero trips and raises a fault flag
    a_r5_expire_trips: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && en && !kick && tick && cnt_q == '0)
        |=> (state_q == ST_TRIP && fault_any));

    // R6: a keyed kick above the window trips
    a_r6_early_trips: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && en && kick && cnt_q > win)
        |=> (state_q == ST_TRIP && fault_any));

    // R12: freeze holds the count when nothing else acts on it
    a_r12_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && en && freeze && !kick) |=> $stable(cnt_q));

endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
    import wwdt_pkg::*;
#(
    parameter int                CNT_W    = 10,
    parameter int                DATA_W   = 16,
    parameter int                PRE_W    = 8,
    parameter int                SEL_W    = 3,
    parameter logic [DATA_W-1:0] KICK_KEY = 16'hA5C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              fault_rst_req,
    output logic              fault_irq,
    output logic              warn_irq
);
    wd_ctrl_t         ctrl;
    logic [CNT_W-1:0] win, warn_lvl, reload_val, cnt;
    logic             kick, tick, adv, clr;
    logic             ev_warn, ev_under, ev_early;
    logic             flag_warn, flag_under, flag_early, fault_any;

    wwdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .KICK_KEY(KICK_KEY)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .ev_warn    (ev_warn),
        .ev_under   (ev_under),
        .ev_early   (ev_early),
        .cnt_val    (cnt),
        .ctrl       (ctrl),
        .win        (win),
        .warn_lvl   (warn_lvl),
        .reload_val (reload_val),
        .kick       (kick),
        .flag_warn  (flag_warn),
        .flag_under (flag_under),
        .flag_early (flag_early),
        .bus_rdata  (bus_rdata)
    );

    wwdt_clkdiv #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .adv      (adv),
        .pre_sel  (ctrl.pre_sel),
        .post_sel (ctrl.post_sel),
        .tick     (tick)
    );

    wwdt_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (ctrl.en),
        .freeze     (freeze),
        .kick       (kick),
        .tick       (tick),
        .fault_any  (fault_any),
        .win        (win),
        .warn_lvl   (warn_lvl),
        .reload_val (reload_val),
        .cnt_q      (cnt),
        .adv        (adv),
        .clr        (clr),
        .ev_warn    (ev_warn),
        .ev_under   (ev_under),
        .ev_early   (ev_early)
    );

    always_comb begin
        fault_any     = flag_under || flag_early;
        fault_rst_req = fault_any && !ctrl.act_irq;
        fault_irq     = fault_any && ctrl.act_irq;
        warn_irq      = flag_warn;
    end

    // R10: the two fault outputs are never high together
    a_r10_one_route: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_rst_req && fault_irq));

endmodule

// File: tb/sim_wwdt_top.sv
module sim_wwdt_top;
    localparam int KEY = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freeze = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd6;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        fault_rst_req, fault_irq, warn_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wwdt_top u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .freeze        (freeze),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .fault_rst_req (fault_rst_req),
        .fault_irq     (fault_irq),
        .warn_irq      (warn_irq)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: 0 idle, 1 run, 2 trip
    int m_state, m_cnt, m_phase, m_ctrl, m_win, m_warn, m_rel, m_flags;

    function automatic int m_read(input int a);
        case (a)
            0: return m_ctrl;
            1: return m_win;
            2: return m_warn;
            3: return m_rel;
            5: return m_flags;
            6: return m_cnt;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int  p, ns, ev, clrm;
        bit  en, kick, tick, ld, dec;
        if (!rst_n) begin
            m_state = 0; m_cnt = 1023; m_phase = 0; m_ctrl = 0;
            m_win = 1023; m_warn = 0; m_rel = 1023; m_flags = 0;
        end else begin
            p    = (((m_ctrl >> 2) & 1) != 0 ? 256 : 1) << ((m_ctrl >> 3) & 7);
            en   = (m_ctrl & 1) != 0;
            kick = bus_wr && bus_addr == 3'd4 && int'(bus_wdata) == KEY;
            tick = (m_state == 1) && !freeze && (m_phase == p - 1);
            ns = m_state; ld = 0; dec = 0; ev = 0;
            case (m_state)
                0: if (en) begin ns = 1; ld = 1; end
                1: begin
                    if (!en) ns = 0;
                    else if (kick) begin
                        if (m_cnt <= m_win) ld = 1;
                        else begin ev = 4; ns = 2; end
                    end else if (tick) begin
                        if (m_cnt == 0) begin ev = 2; ns = 2; end
                        else begin dec = 1; if (m_cnt - 1 == m_warn) ev = 1; end
                    end
                end
                default: begin
                    if (!en) ns = 0;
                    else if ((m_flags & 6) == 0) begin ns = 1; ld = 1; end
                end
            endcase
            if (ld || m_state != 1) m_phase = 0;
            else if (!freeze) m_phase = (m_phase == p - 1) ? 0 : m_phase + 1;
            if (ld) m_cnt = m_rel;
            else if (dec) m_cnt = m_cnt - 1;
            clrm = (bus_wr && bus_addr == 3'd5) ? int'(bus_wdata[2:0]) : 0;
            m_flags = (m_flags & ~clrm & 7) | ev;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_ctrl = int'(bus_wdata[5:0]);
                    3'd1: m_win  = int'(bus_wdata[9:0]);
                    3'd2: m_warn = int'(bus_wdata[9:0]);
                    3'd3: m_rel  = int'(bus_wdata[9:0]);
                    default: ;
                endcase
            end
            m_state = ns;
        end
    end

    // every-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(fault_rst_req), int'((m_flags & 6) != 0 && (m_ctrl & 2) == 0), "R10 fault_rst_req");
            chk(int'(fault_irq), int'((m_flags & 6) != 0 && (m_ctrl & 2) != 0), "R10 fault_irq");
            chk(int'(warn_irq), m_flags & 1, "R9 warn_irq");
            chk(int'(bus_rdata), m_read(int'(bus_addr)), "R4 read data");
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
        @(posedge clk); #2;
        bus_wr = 1'b0; bus_addr = 3'd6; bus_wdata = 16'h0;
    endtask

    task automatic rd_now(output int v);
        @(negedge clk); #1;
        v = int'(bus_rdata);
    endtask

    task automatic rd(input int a, output int v);
        @(posedge clk); #2;
        bus_addr = 3'(a);
        @(negedge clk); #1;
        v = int'(bus_rdata);
        #3 bus_addr = 3'd6;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int v, v1;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset values
        rd(0, v); chk(v, 0, "R1 control");
        rd(1, v); chk(v, 1023, "R1 window");
        rd(2, v); chk(v, 0, "R1 warning");
        rd(3, v); chk(v, 1023, "R1 reload");
        rd(4, v); chk(v, 0, "R1 kick");
        rd(5, v); chk(v, 0, "R1 status");
        rd(6, v); chk(v, 1023, "R1 count");
        chk(int'(fault_rst_req | fault_irq | warn_irq), 0, "R1 outputs");

        // R3 start, R4 decrement
        wr(3, 20); wr(2, 5); wr(0, 1);
        rd_now(v);
        rd_now(v); chk(v, 20, "R3 start loads reload");
        rd_now(v); chk(v, 19, "R4 one step per tick");

        // R9 warning at level 5
        for (int i = 0; i < 40; i++) begin rd_now(v); if (v == 5) break; end
        chk(int'(warn_irq), 1, "R9 warning at level");
        // R7 kick inside a fully open window
        wr(4, KEY);
        rd_now(v); chk(v, 20, "R7 kick reloads");
        wr(5, 1);
        rd_now(v); chk(int'(warn_irq), 0, "R9 warning cleared");

        // R7 boundary: kick with count equal to window
        wr(1, 3);
        for (int i = 0; i < 40; i++) begin rd_now(v); if (v == 4) break; end
        wr(4, KEY);
        rd_now(v); chk(v, 20, "R7 kick at window edge");
        // R8 wrong key ignored
        wr(4, 16'h1234);
        rd(5, v); chk((v >> 1) & 3, 0, "R8 wrong key");

        // R6 early kick one above window
        for (int i = 0; i < 40; i++) begin rd_now(v); if (v == 5) break; end
        wr(4, KEY);
        rd_now(v); chk(v, 4, "R6 no reload on early kick");
        chk(int'(fault_rst_req), 1, "R10 reset route");
        rd(5, v); chk((v >> 2) & 1, 1, "R6 early flag");

        // R11 recover
        wr(5, 6);
        rd_now(v);
        rd_now(v); chk(v, 20, "R11 recover reloads");
        chk(int'(fault_rst_req), 0, "R11 fault cleared");

        // R5 underflow routed to interrupt
        wr(0, 3);
        for (int i = 0; i < 40; i++) begin rd_now(v); if (v == 0) break; end
        rd_now(v);
        chk(int'(fault_irq), 1, "R10 interrupt route");
        chk(int'(fault_rst_req), 0, "R10 no reset on irq route");
        rd(5, v); chk((v >> 1) & 1, 1, "R5 underflow flag");
        wr(5, 7);

        // R12 freeze
        @(posedge clk); #2 freeze = 1'b1;
        rd_now(v1);
        repeat (30) @(negedge clk);
        rd_now(v); chk(v, v1, "R12 freeze holds");
        @(posedge clk); #2 freeze = 1'b0;

        // R3 stop holds, R8 kick in idle ignored
        wr(0, 0);
        rd_now(v1);
        repeat (10) @(negedge clk);
        rd_now(v); chk(v, v1, "R3 idle holds");
        wr(4, KEY);
        rd_now(v); chk(v, v1, "R8 kick in idle");

        // R2 divider 256 x 2
        wr(3, 3); wr(0, 13);
        rd_now(v);
        rd_now(v); chk(v, 3, "R2 load");
        repeat (510) @(negedge clk);
        rd_now(v); chk(v, 3, "R2 before period 512");
        rd_now(v); chk(v, 2, "R2 at period 512");

        // R2 divider 1 x 8, then underflow on reset route
        wr(0, 0); wr(0, 25);
        rd_now(v);
        rd_now(v); chk(v, 3, "R2 load");
        repeat (6) @(negedge clk);
        rd_now(v); chk(v, 3, "R2 before period 8");
        rd_now(v); chk(v, 2, "R2 at period 8");
        for (int i = 0; i < 100; i++) begin rd(5, v); if (((v >> 1) & 1) == 1) break; end
        chk((v >> 1) & 1, 1, "R5 underflow flag");
        chk(int'(fault_rst_req), 1, "R10 reset route on underflow");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule